// File: doc/BRIEF.md
# External Interrupt Request Flag Register

This block watches eight active-low external request pins and reports their state in one 16-bit status register that software reads and writes over a simple single-register bus. Each pin passes through a two-flop synchronizer and is then judged by its own detection mode, picked by a 2-bit select field from a separate control register. In level mode a flag follows the pin. In edge modes a flag latches and stays set until software clears it with a read-then-write-zero handshake.

A registered interrupt line is the OR of all eight flags. It lets an interrupt controller know that at least one request is pending. Arbitration, vector generation and the control register itself belong elsewhere.

Top module: `xreq_flags`

## Requirements
- R1: A read strobe on `rd_en` places the eight flags on `rd_data[7:0]` (bit i holds pin i) in the next cycle. `rd_data` is all zero in any cycle after a cycle without a read strobe.
- R2: `rd_data[15:8]` always reads 0. Write data in bits 15 to 8 has no effect on any state.
- R3: With select code 00 (low level), flag i reads 1 while pin i is low and 0 while it is high. The flag updates 3 clock edges after the pin changes and needs no software clear.
- R4: Select codes 01, 10 and 11 set flag i on a falling edge, a rising edge or either edge of pin i. The flag is set 3 clock edges after the pin changes and stays set after the pin returns.
- R5: An edge-mode flag is cleared only by a write with a 0 in its bit, and only if a read has returned 1 for that bit since the last clear. A qualifying clear consumes that record, so a second write of 0 without a new read is ignored.
- R6: Writing 1 to a flag bit never sets or changes that flag.
- R7: After reset every flag, `rd_data` and `irq` are 0.
- R8: `irq` is the OR of the eight flags, delayed by one register stage.
- R9: If a selected edge arrives in the same cycle as a qualifying clear, the flag remains set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 8 | Asynchronous active-low request pins |
| det_sel | input | 16 | Detection select, bits [2i+1:2i] for pin i |
| rd_en | input | 1 | Read strobe of the status register |
| wr_en | input | 1 | Write strobe of the status register |
| wr_data | input | 16 | Write data; a 0 in bits 7..0 requests a clear |
| rd_data | output | 16 | Registered read data |
| irq | output | 1 | Registered combined request |

## Verification
Level mode is driven through a table of pin patterns: alternating, walking-zero, all-low and all-high. These show that each flag follows its own pin, with no swapped or stuck bits. Edge mode uses a mixed select word, so that the falling, rising and both-edge pins get the same stimulus and only the chosen edge sets a flag. Clear tests write zero to flags that were read and to flags that were not, and write ones and reserved bits. These tell the read-record rule apart from a plain write-zero clear. A clear timed against a fresh edge shows that the new edge wins.

// File: rtl/xreq_pkg.sv
package xreq_pkg;
  typedef enum logic [1:0] {
    DET_LOW  = 2'b00,
    DET_FALL = 2'b01,
    DET_RISE = 2'b10,
    DET_BOTH = 2'b11
  } det_mode_e;
endpackage

// File: rtl/xreq_sync.sv
module xreq_sync #(
  parameter int WIDTH = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  // Reset to 1: pins are idle-high, so no false edge after reset.
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/xreq_cell.sv
module xreq_cell
  import xreq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pin_s,
  input  det_mode_e mode,
  input  logic      rd_hit,
  input  logic      wr_zero,
  output logic      flag,
  output logic      seen,
  output logic      hit
);
  logic prev_q, flag_q, seen_q;
  logic fall, rise, clr;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= pin_s;
  end

  assign fall = prev_q & ~pin_s;
  assign rise = ~prev_q & pin_s;

  always_comb begin
    unique case (mode)
      DET_FALL: hit = fall;
      DET_RISE: hit = rise;
      DET_BOTH: hit = fall | rise;
      default:  hit = 1'b0;
    endcase
  end

  assign clr = wr_zero & seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      seen_q <= 1'b0;
    end else if (mode == DET_LOW) begin
      flag_q <= ~pin_s;
      seen_q <= 1'b0;
    end else begin
      flag_q <= hit | (flag_q & ~clr);
      if (clr)                  seen_q <= 1'b0;
      else if (rd_hit & flag_q) seen_q <= 1'b1;
    end
  end

  assign flag = flag_q;
  assign seen = seen_q;
endmodule

// File: rtl/xreq_flags.sv
module xreq_flags
  import xreq_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int REG_W  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_PINS-1:0]   req_n,
  input  logic [2*N_PINS-1:0] det_sel,
  input  logic                rd_en,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  output logic [REG_W-1:0]    rd_data,
  output logic                irq
);
  localparam int SEL_W = 2;

  logic [N_PINS-1:0] pin_sync;
  logic [N_PINS-1:0] flag_vec;
  logic [N_PINS-1:0] seen_vec;
  logic [N_PINS-1:0] hit_vec;
  logic [REG_W-1:0]  rd_next;

  xreq_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (req_n),
    .dout (pin_sync)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_cell
    xreq_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .pin_s   (pin_sync[i]),
      .mode    (det_mode_e'(det_sel[SEL_W*i +: SEL_W])),
      .rd_hit  (rd_en),
      .wr_zero (wr_en & ~wr_data[i]),
      .flag    (flag_vec[i]),
      .seen    (seen_vec[i]),
      .hit     (hit_vec[i])
    );
  end

  always_comb begin
    rd_next = '0;
    if (rd_en) rd_next[N_PINS-1:0] = flag_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      rd_data <= rd_next;
      irq     <= |flag_vec;
    end
  end
endmodule

// File: rtl/xreq_flags_chk.sv
module xreq_flags_chk #(
  parameter int N_PINS = 8,
  parameter int REG_W  = 16
) (
  input logic                clk,
  input logic                rst,
  input logic [2*N_PINS-1:0] det_sel,
  input logic                rd_en,
  input logic [N_PINS-1:0]   pin_sync,
  input logic [N_PINS-1:0]   flag_vec,
  input logic [N_PINS-1:0]   seen_vec,
  input logic [N_PINS-1:0]   hit_vec,
  input logic [REG_W-1:0]    rd_data,
  input logic                irq
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data[REG_W-1:N_PINS] == '0);

  a_r1_read_data: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_data[N_PINS-1:0] == $past(flag_vec));

  a_r8_irq_or: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|flag_vec));

  for (genvar i = 0; i < N_PINS; i++) begin : g_bit
    a_r3_level_follow: assert property (@(posedge clk) disable iff (rst)
      (det_sel[2*i +: 2] == 2'b00) |=> (flag_vec[i] == !$past(pin_sync[i])));

    a_r5_no_record_hold: assert property (@(posedge clk) disable iff (rst)
      (det_sel[2*i +: 2] != 2'b00 && flag_vec[i] && !seen_vec[i] && !hit_vec[i])
        |=> flag_vec[i]);

    a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
      (det_sel[2*i +: 2] != 2'b00 && !flag_vec[i] && !hit_vec[i]) |=> !flag_vec[i]);

    a_r9_edge_wins: assert property (@(posedge clk) disable iff (rst)
      (det_sel[2*i +: 2] != 2'b00 && hit_vec[i]) |=> flag_vec[i]);
  end
endmodule

bind xreq_flags xreq_flags_chk #(.N_PINS(N_PINS), .REG_W(REG_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .det_sel  (det_sel),
  .rd_en    (rd_en),
  .pin_sync (pin_sync),
  .flag_vec (flag_vec),
  .seen_vec (seen_vec),
  .hit_vec  (hit_vec),
  .rd_data  (rd_data),
  .irq      (irq)
);

// File: tb/sim_xreq_flags.sv
`timescale 1ns/1ps
module sim_xreq_flags;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  req_n = 8'hFF;
  logic [15:0] det_sel = 16'h0000;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0000;
  logic [15:0] rd_data;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xreq_flags u0 (
    .clk(clk), .rst(rst), .req_n(req_n), .det_sel(det_sel),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  // {pins, expected flags} for level mode
  localparam logic [15:0] LVL_VEC [6] = '{
    16'hAA_55, 16'h55_AA, 16'hFE_01, 16'h7F_80, 16'h00_FF, 16'hFF_00
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(output logic [15:0] v);
    @(negedge clk); rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk); v = rd_data; rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0; wr_data = 16'h0000;
  endtask

  task automatic set_pins(input logic [7:0] p);
    @(negedge clk); req_n = p;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 rd_data after reset", rd_data, 16'h0000);
    check("R7 irq after reset", {15'd0, irq}, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    do_read(v);
    check("R7 flags after reset", v, 16'h0000);
    check("R1 rd_data idle zero", rd_data, 16'h0000);

    // Level mode table (R3, R1, R8)
    for (int k = 0; k < 6; k++) begin
      set_pins(LVL_VEC[k][15:8]);
      check("R8 irq level", {15'd0, irq}, {15'd0, |LVL_VEC[k][7:0]});
      do_read(v);
      check("R3 level flags", v, {8'h00, LVL_VEC[k][7:0]});
    end
    // R3 one-cycle timing: flag follows at third edge
    @(negedge clk); req_n = 8'hFE;
    repeat (2) @(posedge clk);
    @(negedge clk); rd_en = 1'b1;
    @(posedge clk); @(negedge clk); rd_en = 1'b0;
    check("R3 level not before third edge", rd_data, 16'h0000);
    do_read(v);
    check("R3 level after third edge", v, 16'h0001);
    set_pins(8'hFF);

    // Edge modes: pin0 fall, pin1 rise, pin2 both, others fall (R4)
    det_sel = 16'h5579;
    set_pins(8'hFD);
    do_read(v);
    check("R4 rise-mode pin ignores fall", v, 16'h0000);
    set_pins(8'hFF);
    do_read(v);
    check("R4 rise-mode pin sets on rise", v, 16'h0002);
    set_pins(8'hFB);
    do_read(v);
    check("R4 both-mode pin sets on fall", v, 16'h0006);
    set_pins(8'hFF);
    set_pins(8'hFE);
    set_pins(8'hFF);
    check("R8 irq with edge flags", {15'd0, irq}, 16'h0001);
    // R5: bit0 was never read, bits1,2 were
    do_write(16'h0000);
    do_read(v);
    check("R5 clear only read flags", v, 16'h0001);
    do_write(16'h0000);
    do_read(v);
    check("R5 clear after read", v, 16'h0000);
    @(negedge clk);
    check("R8 irq low after clear", {15'd0, irq}, 16'h0000);

    // R6 / R2: writing ones sets nothing
    do_write(16'hFFFF);
    do_read(v);
    check("R6 R2 write ones sets nothing", v, 16'h0000);
    set_pins(8'hFB);
    do_read(v);
    check("R4 both-mode flag set", v, 16'h0004);
    do_write(16'h0004);
    do_read(v);
    check("R6 write one keeps flag", v, 16'h0004);
    do_write(16'hFFFB);
    do_read(v);
    check("R5 write zero clears bit2", v, 16'h0000);

    // R9: new edge in same cycle as a qualifying clear
    set_pins(8'hFF);
    do_read(v);
    check("R9 setup flag", v, 16'h0004);
    @(negedge clk); req_n = 8'hFB;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1'b1; wr_data = 16'h0000;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
    do_write(16'h0000);
    do_read(v);
    check("R9 edge wins and R5 record consumed", v, 16'h0004);

    // R3 again: back to level mode, pins high
    det_sel = 16'h0000;
    set_pins(8'hFF);
    do_read(v);
    check("R3 level after mode change", v, 16'h0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule